// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a synthesizable behavioural model of a single-clock burst SRAM of the kind used as a processor's secondary cache. Every synchronous input is registered on the rising clock edge. Read data comes back through an output register, so a read issued at one edge shows up after the next edge. The data word is 64 bits wide and split into eight byte lanes. A write can update any subset of those lanes.

An access is opened by one of two active-low start strobes. The processor strobe is masked by the primary chip enable and always opens as a read. The controller strobe can open either a read or a write. Once a burst is open, the advance input steps an internal 2-bit counter through a 4-word block, in either interleaved or linear order (a parameter picks the order). Holding advance off repeats the current word, which inserts wait states. A sleep input parks the block with its contents kept. After sleep is released, start strobes are locked out for two cycles, and any strobe seen during that window sets a sticky error flag. Instead of tri-state pads, the model gives a drive-enable flag beside the read data.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read command sampled at clock edge k puts the word on rdata_o, with rdata_en_o high, after edge k+1 and not after edge k.
- R2: An access starts only if, at the start strobe, ce_ni=0, ce2_i=1 and ce3_ni=0. A start strobe with any of these unmet deselects the block, and the next output has rdata_en_o=0. In cycles with no start strobe, the three chip enables are ignored.
- R3: While ce_ni=1, adsp_ni=0 starts nothing. If adsc_ni=1 in that cycle, an open burst continues or suspends as set by adv_ni, at its own address.
- R4: A start by adsp_ni always reads, whatever the write inputs are. A write on the next cycle (no strobe, adv_ni=1) stores to the same address.
- R5: A start by adsc_ni with a write request stores wdata_i at addr_i in that same cycle.
- R6: A write request exists when gw_ni=0 (all lanes written) or when bwe_ni=0 and bw_ni has at least one 0. Lane n, bits 8n+7..8n, is written when bw_ni[n]=0. With gw_ni=1 and bwe_ni=1, the cycle is a read whatever bw_ni holds.
- R7: With no start strobe, adv_ni=0 moves to the next burst word and adv_ni=1 repeats the current one. The burst offset is the start address's two low bits XOR the count (interleaved), or their sum mod 4 (linear). It wraps inside the aligned 4-word block.
- R8: rdata_en_o is high only when the last edge loaded read data, oe_ni=0 and sleep_i=0, and rdata_o is zero while it is low. oe_ni acts without a clock. Write and deselect cycles never drive.
- R9: While sleep_i=1, no access takes place, the output is disabled, any open burst is closed, and the stored data is kept.
- R10: For the 2 cycles after sleep_i falls, both start strobes are ignored. A strobe asserted in that window sets lock_err_o, which stays set until reset.
- R11: A read issued in the cycle right after a byte write to the same address returns the newly written lanes merged with the unchanged ones.
- R12: After reset, rdata_en_o=0, lock_err_o=0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| adsp_ni | input | 1 | Processor start strobe, active low |
| adsc_ni | input | 1 | Controller start strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Write all lanes, active low |
| bwe_ni | input | 1 | Byte-write qualifier, active low |
| bw_ni | input | LANES | Per-lane write strobes, active low |
| ce_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Secondary chip enable, active high |
| ce3_ni | input | 1 | Tertiary chip enable, active low |
| oe_ni | input | 1 | Output enable, active low, unclocked |
| sleep_i | input | 1 | Power-down request |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_en_o | output | 1 | Read data drive enable |
| lock_err_o | output | 1 | Sticky start-during-recovery flag |

## Verification
The bench builds two copies side by side from the same stimulus. Both use the default 6-bit address (64 words), eight 8-bit lanes, a 2-bit burst counter and a 2-cycle recovery. One copy steps bursts in interleaved order and the other in linear order. Because the stimulus is shared, a burst that starts mid-block shows the two orders diverging, then wrapping back to the start word, in the same run. The small depth lets the bench keep a full reference copy of every word it has written.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  typedef enum logic {
    ORDER_INTERLEAVE = 1'b0,
    ORDER_LINEAR     = 1'b1
  } burst_order_e;
endpackage

// File: rtl/pbsram_burst_seq.sv
module pbsram_burst_seq
  import pbsram_pkg::*;
#(
  parameter int           ADDR_W  = 6,
  parameter int           BURST_W = 2,
  parameter burst_order_e ORDER   = ORDER_INTERLEAVE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q, step, offs;

  assign step = adv_i ? cnt_q + 1'b1 : cnt_q;

  generate
    if (ORDER == ORDER_LINEAR) begin : g_linear
      assign offs = base_q[BURST_W-1:0] + step;
    end else begin : g_interleave
      assign offs = base_q[BURST_W-1:0] ^ step;
    end
  endgenerate

  assign addr_o = load_i ? addr_i : {base_q[ADDR_W-1:BURST_W], offs};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
    end else if (adv_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_HOLD_ON_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(cnt_q) && $stable(base_q)); // R7
endmodule

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl #(
  parameter int LANES       = 8,
  parameter int RECOVER_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             adsp_ni,
  input  logic             adsc_ni,
  input  logic             adv_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             ce_ni,
  input  logic             ce2_i,
  input  logic             ce3_ni,
  output logic             load_o,
  output logic             adv_o,
  output logic             acc_vld_o,
  output logic             acc_wr_o,
  output logic [LANES-1:0] wmask_o,
  output logic             err_o
);
  localparam int RW = $clog2(RECOVER_CYC + 1);

  logic          burst_q, burst_d, err_q;
  logic [RW-1:0] rec_q;
  logic          locked, awake, sel, p_go, c_go, wr_req;

  assign locked = !sleep_i && (rec_q != '0);
  assign awake  = !sleep_i && (rec_q == '0);
  assign sel    = !ce_ni && ce2_i && !ce3_ni;
  assign p_go   = !adsp_ni && !ce_ni;       // primary enable masks this strobe
  assign c_go   = !adsc_ni && !p_go;
  assign wmask_o = !gw_ni ? '1 : (!bwe_ni ? ~bw_ni : '0);
  assign wr_req  = |wmask_o;

  always_comb begin
    load_o    = 1'b0;
    adv_o     = 1'b0;
    acc_vld_o = 1'b0;
    acc_wr_o  = 1'b0;
    burst_d   = burst_q;
    if (sleep_i) begin
      burst_d = 1'b0;
    end else if (awake) begin
      if (p_go || c_go) begin
        load_o    = sel;
        acc_vld_o = sel;
        acc_wr_o  = c_go && wr_req;
        burst_d   = sel;
      end else if (burst_q) begin
        acc_vld_o = 1'b1;
        adv_o     = !adv_ni;
        acc_wr_o  = wr_req;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= 1'b0;
      rec_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      burst_q <= burst_d;
      if (sleep_i)           rec_q <= RW'(RECOVER_CYC);
      else if (rec_q != '0)  rec_q <= rec_q - 1'b1;
      if (locked && (!adsp_ni || !adsc_ni)) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  AST_ADSP_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_ni && ce_ni && adsc_ni && !burst_q) |-> !acc_vld_o); // R3
  AST_PSTART_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_ni && !ce_ni) |-> !acc_wr_o); // R4
  AST_LOCK_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && (!adsp_ni || !adsc_ni)) |=> err_o); // R10
  AST_LOCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |-> !acc_vld_o && !load_o); // R10
endmodule

// File: rtl/pbsram_array.sv
module pbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [LANES-1:0]        wmask_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvld_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (wr_i && wmask_i[l]) mem_q[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (rd_i) rd_q <= mem_q[addr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvld_o <= 1'b0;
    else         rvld_o <= rd_i;
  end
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import pbsram_pkg::*;
#(
  parameter int           ADDR_W      = 6,
  parameter int           LANES       = 8,
  parameter int           LANE_W      = 8,
  parameter int           BURST_W     = 2,
  parameter int           RECOVER_CYC = 2,
  parameter burst_order_e BURST_ORDER = ORDER_INTERLEAVE
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    adsp_ni,
  input  logic                    adsc_ni,
  input  logic                    adv_ni,
  input  logic                    gw_ni,
  input  logic                    bwe_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic                    ce_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdata_en_o,
  output logic                    lock_err_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              load, adv, acc_vld, acc_wr;
  logic [LANES-1:0]  wmask;
  logic [ADDR_W-1:0] acc_addr;

  logic              s1_vld_q, s1_wr_q;
  logic [LANES-1:0]  s1_mask_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [DATA_W-1:0] s1_wdata_q;

  logic [DATA_W-1:0] arr_q;
  logic              arr_vld;

  pbsram_ctrl #(.LANES(LANES), .RECOVER_CYC(RECOVER_CYC)) u_ctrl (
    .clk_i, .rst_ni, .sleep_i, .adsp_ni, .adsc_ni, .adv_ni, .gw_ni, .bwe_ni,
    .bw_ni, .ce_ni, .ce2_i, .ce3_ni,
    .load_o(load), .adv_o(adv), .acc_vld_o(acc_vld), .acc_wr_o(acc_wr),
    .wmask_o(wmask), .err_o(lock_err_o)
  );

  pbsram_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .ORDER(BURST_ORDER)) u_seq (
    .clk_i, .rst_ni, .load_i(load), .adv_i(adv), .addr_i, .addr_o(acc_addr)
  );

  // input register stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q   <= 1'b0;
      s1_wr_q    <= 1'b0;
      s1_mask_q  <= '0;
      s1_addr_q  <= '0;
      s1_wdata_q <= '0;
    end else begin
      s1_vld_q   <= acc_vld;
      s1_wr_q    <= acc_wr;
      s1_mask_q  <= wmask;
      s1_addr_q  <= acc_addr;
      s1_wdata_q <= wdata_i;
    end
  end

  // array write lands one edge before any following read samples it
  pbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .rst_ni,
    .wr_i(s1_vld_q && s1_wr_q), .rd_i(s1_vld_q && !s1_wr_q),
    .wmask_i(s1_mask_q), .addr_i(s1_addr_q), .wdata_i(s1_wdata_q),
    .rdata_o(arr_q), .rvld_o(arr_vld)
  );

  assign rdata_en_o = arr_vld && !oe_ni && !sleep_i;
  assign rdata_o    = rdata_en_o ? arr_q : '0;

  AST_WR_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld_q && s1_wr_q) |=> !rdata_en_o); // R8
  AST_SLEEP_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !s1_vld_q); // R9
  AST_EN_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_en_o |-> !oe_ni && $past(s1_vld_q && !s1_wr_q)); // R1
endmodule

// File: tb/pipe_burst_sram_test.sv
`timescale 1ns/1ps
module pipe_burst_sram_test;
  import pbsram_pkg::*;

  logic        clk = 0, rst_n = 0;
  logic [5:0]  addr;
  logic        adsp_n, adsc_n, adv_n, gw_n, bwe_n, ce_n, ce2, ce3_n, oe_n, sleep;
  logic [7:0]  bw_n;
  logic [63:0] wdata;
  logic [63:0] rd, rd_l;
  logic        rd_en, rd_en_l, err, err_l;

  int n_chk = 0, n_bad = 0;
  logic [63:0] ref_mem [64];

  always #2 clk = ~clk;

  pipe_burst_sram #(.BURST_ORDER(ORDER_INTERLEAVE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .adsp_ni(adsp_n), .adsc_ni(adsc_n),
    .adv_ni(adv_n), .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .ce_ni(ce_n),
    .ce2_i(ce2), .ce3_ni(ce3_n), .oe_ni(oe_n), .sleep_i(sleep), .wdata_i(wdata),
    .rdata_o(rd), .rdata_en_o(rd_en), .lock_err_o(err));

  pipe_burst_sram #(.BURST_ORDER(ORDER_LINEAR)) uut_lin (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .adsp_ni(adsp_n), .adsc_ni(adsc_n),
    .adv_ni(adv_n), .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .ce_ni(ce_n),
    .ce2_i(ce2), .ce3_ni(ce3_n), .oe_ni(oe_n), .sleep_i(sleep), .wdata_i(wdata),
    .rdata_o(rd_l), .rdata_en_o(rd_en_l), .lock_err_o(err_l));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_sigs;
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
    ce_n = 0; ce2 = 1; ce3_n = 0; oe_n = 0; sleep = 0;
  endtask

  task automatic model_wr(logic [5:0] a, logic [7:0] lanes, logic [63:0] d);
    for (int l = 0; l < 8; l++)
      if (lanes[l]) ref_mem[a][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic c_rd(logic [5:0] a);
    idle_sigs; adsc_n = 0; addr = a; tick;
  endtask

  task automatic c_wr(logic [5:0] a, logic [7:0] lanes, logic [63:0] d, bit use_gw);
    idle_sigs; adsc_n = 0; addr = a; wdata = d;
    if (use_gw) begin gw_n = 0; lanes = '1; end
    else begin bwe_n = 0; bw_n = ~lanes; end
    model_wr(a, lanes, d);
    tick;
  endtask

  task automatic c_desel;
    idle_sigs; adsc_n = 0; ce_n = 1; tick;
  endtask

  task automatic c_cont(bit step);
    idle_sigs; adv_n = !step; tick;
  endtask

  task automatic t_reset;
    chk("R12 en in reset", 64'(rd_en), 64'(0));
    chk("R12 err in reset", 64'(err), 64'(0));
    rst_n = 1;
    tick; tick;
    chk("R12 en after reset", 64'(rd_en), 64'(0));
    chk("R12 err after reset", 64'(err), 64'(0));
  endtask

  task automatic t_write_read;
    c_wr(6'd5, '1, 64'h1111_2222_3333_4444, 1);
    c_rd(6'd5);
    chk("R1 no data one edge after read", 64'(rd_en), 64'(0));
    c_desel;
    chk("R1 en two edges after read", 64'(rd_en), 64'(1));
    chk("R5 R1 read data", rd, ref_mem[5]);
    c_desel;
    chk("R8 deselect no drive", 64'(rd_en), 64'(0));
  endtask

  task automatic t_bytes;
    c_wr(6'd6, '1, 64'hA0A1_A2A3_A4A5_A6A7, 1);
    c_wr(6'd6, 8'h55, 64'h0B1B_2B3B_4B5B_6B7B, 0);
    c_rd(6'd6); c_desel;
    chk("R6 lane mask merge", rd, ref_mem[6]);
    idle_sigs; adsc_n = 0; addr = 6'd6; bw_n = 8'h00; wdata = 64'hDEAD_BEEF_DEAD_BEEF; tick;
    c_desel;
    chk("R6 strobes without qualifier read en", 64'(rd_en), 64'(1));
    chk("R6 strobes without qualifier no write", rd, ref_mem[6]);
  endtask

  task automatic t_fwd;
    c_wr(6'd7, '1, 64'h7777_7777_7777_7777, 1);
    c_wr(6'd7, 8'h0F, 64'h0123_4567_89AB_CDEF, 0);
    c_rd(6'd7); c_desel;
    chk("R11 read after byte write", rd, ref_mem[7]);
  endtask

  task automatic t_pstart;
    c_wr(6'd9, '1, 64'h9999_0000_9999_0000, 1);
    c_desel;
    idle_sigs; adsp_n = 0; addr = 6'd9; gw_n = 0; wdata = 64'hBAD0_BAD0_BAD0_BAD0; tick;
    idle_sigs; gw_n = 0; wdata = 64'h5A5A_C3C3_5A5A_C3C3; model_wr(6'd9, '1, wdata); tick;
    chk("R4 processor start reads en", 64'(rd_en), 64'(1));
    chk("R4 processor start reads old data", rd, 64'h9999_0000_9999_0000);
    c_desel;
    chk("R8 write cycle no drive", 64'(rd_en), 64'(0));
    c_rd(6'd9); c_desel;
    chk("R4 follow-on write stored", rd, ref_mem[9]);
  endtask

  task automatic t_burst;
    int ei [6] = '{17, 16, 16, 19, 18, 17};
    int el [6] = '{17, 18, 18, 19, 16, 17};
    for (int i = 0; i < 4; i++) c_wr(6'(16 + i), '1, {16'hB0B0, 16'(i), 32'hCAFE_0000 + i}, 1);
    c_desel;
    for (int k = 0; k < 6; k++) begin
      if (k == 0) c_rd(6'd17);
      else        c_cont(k != 2);
      if (k > 0) begin
        chk("R7 interleaved word", rd, ref_mem[ei[k-1]]);
        chk("R7 linear word", rd_l, ref_mem[el[k-1]]);
      end
    end
    c_desel;
    chk("R7 interleaved wrap", rd, ref_mem[ei[5]]);
    chk("R7 linear wrap", rd_l, ref_mem[el[5]]);
  endtask

  task automatic t_ce;
    idle_sigs; adsc_n = 0; addr = 6'd5; ce2 = 0; tick;
    c_desel;
    chk("R2 ce2 low deselects", 64'(rd_en), 64'(0));
    idle_sigs; adsc_n = 0; addr = 6'd5; ce3_n = 1; tick;
    c_desel;
    chk("R2 ce3 high deselects", 64'(rd_en), 64'(0));
    c_rd(6'd16);
    idle_sigs; ce_n = 1; ce2 = 0; ce3_n = 1; adv_n = 0; tick;
    c_desel;
    chk("R2 enables ignored in continue", rd, ref_mem[17]);
    chk("R2 enables ignored in continue lin", rd_l, ref_mem[17]);
  endtask

  task automatic t_blocked;
    c_rd(6'd18);
    idle_sigs; adsp_n = 0; ce_n = 1; addr = 6'd5; tick;
    c_desel;
    chk("R3 blocked strobe keeps burst en", 64'(rd_en), 64'(1));
    chk("R3 blocked strobe keeps address", rd, ref_mem[18]);
    idle_sigs; adsp_n = 0; ce_n = 1; addr = 6'd5; tick;
    c_desel;
    chk("R3 blocked strobe starts nothing", 64'(rd_en), 64'(0));
  endtask

  task automatic t_oe;
    c_rd(6'd5); c_desel;
    oe_n = 1; #1;
    chk("R8 oe high disables", 64'(rd_en), 64'(0));
    chk("R8 oe high zero data", rd, 64'(0));
    oe_n = 0; #1;
    chk("R8 oe low drives", rd, ref_mem[5]);
  endtask

  task automatic t_sleep;
    chk("R10 err clear before sleep", 64'(err), 64'(0));
    idle_sigs; sleep = 1; adsc_n = 0; addr = 6'd5;
    tick; tick; tick;
    chk("R9 no output asleep", 64'(rd_en), 64'(0));
    chk("R10 no err while asleep", 64'(err), 64'(0));
    idle_sigs; adsc_n = 0; addr = 6'd5; tick;
    chk("R10 err after locked strobe", 64'(err), 64'(1));
    idle_sigs; adsp_n = 0; addr = 6'd5; tick;
    chk("R10 first locked strobe ignored", 64'(rd_en), 64'(0));
    c_desel;
    chk("R10 second locked strobe ignored", 64'(rd_en), 64'(0));
    c_rd(6'd5); c_desel;
    chk("R9 data kept over sleep", rd, ref_mem[5]);
    chk("R10 err sticky", 64'(err), 64'(1));
  endtask

  initial begin
    idle_sigs; addr = 0; wdata = 0;
    tick;
    t_reset;
    t_write_read;
    t_bytes;
    t_fwd;
    t_pstart;
    t_burst;
    t_ce;
    t_blocked;
    t_oe;
    t_sleep;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule